// File: doc/BRIEF.md
# DMA Channel Burst and Drain Controller

This block runs a single DMA channel. Words come in from a source over burst handshakes, wait in a small channel FIFO, and leave to a destination over a matching handshake. Each side has its own 3-bit burst code. The code sets how many words one granted request moves.

When the channel is the flow controller, a 12-bit down-counter holds the number of destination transfers still to be done. Software can read it back. When it reaches zero the block ends the transfer on its own.

To stop the channel without losing data, software sets halt, waits for the active flag to go low, and then clears enable. Clearing enable early drops whatever is still in the FIFO.

Top module: `dmac_channel`

## Requirements
- R1: After reset both registers read zero, and every handshake output, `chan_active` and `tc` are low.
- R2: The control register holds the transfer size in bits [11:0], the source burst code in [14:12] and the destination burst code in [17:15]. The codes 0 to 7 stand for 1, 4, 8, 16, 32, 64, 128 and 256 words. A granted source request gives one `src_ack` pulse and moves exactly that many words on `src_take`, in consecutive cycles starting in the ack cycle.
- R3: A granted destination request gives one `dst_ack` pulse and moves exactly the decoded number of words on `dst_give`, in consecutive cycles. The words come out in the order they were taken in.
- R4: The config register has enable in bit 0 and flow-controller in bit 1. In flow mode, control bits [11:0] read the count of destination words still outstanding. The count is loaded by a control write and drops by one for each `dst_give`.
- R5: With config bit 1 clear, the transfer size has no effect. Words keep moving, the readback keeps the written value, and `tc` stays low.
- R6: The FIFO holds 4 words. A source request is granted only when the FIFO has room for the whole burst, so a burst code above 4 words is never granted outside flow mode.
- R7: While config bit 18 (halt) is set, no new source request is granted. Destination bursts are shortened to the FIFO occupancy so that the FIFO drains completely.
- R8: Config bit 17 (read-only) and `chan_active` are high exactly when the FIFO holds data.
- R9: In flow mode, the destination word that brings the count to zero raises `tc` for exactly one cycle, and enable reads zero from that cycle on.
- R10: Writing enable to zero while the FIFO holds data empties the FIFO at once. The dropped words are never delivered.
- R11: Control bits [31:18] and config bits [31:19] read as zero whatever is written to them.
- R12: In flow mode, a source burst is cut to the words not yet fetched. The total taken in equals the transfer size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects config |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| src_breq | input | 1 | Source burst request, held until acked |
| src_ack | output | 1 | One-cycle source grant |
| src_take | output | 1 | Source word captured this cycle |
| src_data | input | DATA_W | Source word |
| dst_breq | input | 1 | Destination burst request, held until acked |
| dst_ack | output | 1 | One-cycle destination grant |
| dst_give | output | 1 | Destination word valid this cycle |
| dst_data | output | DATA_W | Destination word |
| chan_active | output | 1 | FIFO holds data |
| tc | output | 1 | Terminal-count pulse |

## Verification
The assertions assume three things about the inputs. `src_data` is valid in every cycle where `src_take` is high. Requests stay high until they are acknowledged. The control register is not rewritten while a flow-controlled transfer is running. The stimulus meets these conditions in three ways. It writes the transfer size only while the channel is disabled. It drives each source word from a sequence counter that advances on every take. In flow mode it uses only burst-code and size pairs whose bursts fit the 4-word FIFO, so a sweep never stalls on a burst that can never be granted.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
   localparam int REG_W   = 32;
   localparam int CODE_W  = 3;
   localparam int LEN_W   = 9;
   localparam int SIZE_W  = 12;

   // control register layout
   localparam int SIZE_LSB = 0;
   localparam int SRC_LSB  = 12;
   localparam int DST_LSB  = 15;

   // config register layout
   localparam int EN_BIT   = 0;
   localparam int FLOW_BIT = 1;
   localparam int ACT_BIT  = 17;
   localparam int HALT_BIT = 18;

   // code 0 -> 1 word, code k>0 -> 2^(k+1) words
   function automatic logic [LEN_W-1:0] burst_items(input logic [CODE_W-1:0] code);
      if (code == '0) return LEN_W'(1);
      return LEN_W'(4) << (code - CODE_W'(1));
   endfunction

   // smaller of a burst length and a wider limit
   function automatic logic [LEN_W-1:0] clip_len(input logic [LEN_W-1:0] len,
                                                 input logic [SIZE_W-1:0] lim);
      if (SIZE_W'(len) > lim) return LEN_W'(lim);
      return len;
   endfunction
endpackage

// File: rtl/dmac_fifo.sv
`timescale 1ns/1ps
module dmac_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] dout,
   output logic [CW-1:0]     count
);
   logic [DATA_W-1:0] slot [DEPTH];
   logic [AW-1:0]     wptr, rptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) wptr <= wptr + AW'(1);
         if (pop)  rptr <= rptr + AW'(1);
         count <= count + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push && !flush) slot[wptr] <= din;
   end

   assign dout = slot[rptr];
endmodule

// File: rtl/dmac_burst_seq.sv
`timescale 1ns/1ps
module dmac_burst_seq #(
   parameter int LEN_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kill,
   input  logic             start,
   input  logic [LEN_W-1:0] len,
   output logic             ack,
   output logic             move
);
   logic [LEN_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left <= '0;
         ack  <= 1'b0;
      end else if (kill) begin
         left <= '0;
         ack  <= 1'b0;
      end else begin
         ack <= start;
         if (start)              left <= len;
         else if (left != '0)    left <= left - LEN_W'(1);
      end
   end

   assign move = (left != '0);
endmodule

// File: rtl/dmac_down_cnt.sv
`timescale 1ns/1ps
module dmac_down_cnt #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] value
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     value <= '0;
      else if (load)                  value <= load_val;
      else if (dec && value != '0)    value <= value - W'(1);
   end
endmodule

// File: rtl/dmac_channel.sv
`timescale 1ns/1ps
module dmac_channel
   import dmac_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              src_breq,
   output logic              src_ack,
   output logic              src_take,
   input  logic [DATA_W-1:0] src_data,
   input  logic              dst_breq,
   output logic              dst_ack,
   output logic              dst_give,
   output logic [DATA_W-1:0] dst_data,
   output logic              chan_active,
   output logic              tc
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || DEPTH > 256 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("dmac_channel: DEPTH must be a power of two from 2 to 256");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("dmac_channel: DATA_W must be positive");
   end

   logic              en_q, flow_q, halt_q;
   logic [CODE_W-1:0] src_code, dst_code;
   logic [SIZE_W-1:0] rem_val, budget;
   logic [CNT_W-1:0]  fifo_count, fifo_free;
   logic              ctl_wr, cfg_wr, en_next, flush, tc_fire;
   logic [LEN_W-1:0]  s_len, d_len, d_len_flow;
   logic              src_start, dst_start;

   assign ctl_wr = reg_wr && !reg_sel;
   assign cfg_wr = reg_wr &&  reg_sel;

   // register state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         flow_q   <= 1'b0;
         halt_q   <= 1'b0;
         src_code <= '0;
         dst_code <= '0;
         tc       <= 1'b0;
      end else begin
         en_q <= en_next;
         tc   <= tc_fire;
         if (cfg_wr) begin
            flow_q <= reg_wdata[FLOW_BIT];
            halt_q <= reg_wdata[HALT_BIT];
         end
         if (ctl_wr) begin
            src_code <= reg_wdata[SRC_LSB +: CODE_W];
            dst_code <= reg_wdata[DST_LSB +: CODE_W];
         end
      end
   end

   assign tc_fire = en_q && flow_q && dst_give && (rem_val == SIZE_W'(1)) && !ctl_wr;

   always_comb begin
      en_next = en_q;
      if (cfg_wr)       en_next = reg_wdata[EN_BIT];
      else if (tc_fire) en_next = 1'b0;
   end

   assign flush = en_q && !en_next;

   // counters: destination remaining (readable) and source budget
   dmac_down_cnt #(.W(SIZE_W)) u_rem (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ctl_wr),
      .load_val (reg_wdata[SIZE_LSB +: SIZE_W]),
      .dec      (flow_q && dst_give),
      .value    (rem_val)
   );

   dmac_down_cnt #(.W(SIZE_W)) u_budget (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ctl_wr),
      .load_val (reg_wdata[SIZE_LSB +: SIZE_W]),
      .dec      (flow_q && src_take),
      .value    (budget)
   );

   // burst length selection
   assign fifo_free  = CNT_W'(DEPTH) - fifo_count;
   assign s_len      = flow_q ? clip_len(burst_items(src_code), budget)
                              : burst_items(src_code);
   assign d_len_flow = flow_q ? clip_len(burst_items(dst_code), rem_val)
                              : burst_items(dst_code);
   assign d_len      = halt_q ? clip_len(d_len_flow, SIZE_W'(fifo_count)) : d_len_flow;

   assign src_start = en_q && !halt_q && src_breq && !src_take
                   && (s_len != '0) && (LEN_W'(fifo_free) >= s_len);
   assign dst_start = en_q && dst_breq && !dst_give
                   && (d_len != '0) && (LEN_W'(fifo_count) >= d_len);

   dmac_burst_seq #(.LEN_W(LEN_W)) u_src_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .kill  (flush),
      .start (src_start),
      .len   (s_len),
      .ack   (src_ack),
      .move  (src_take)
   );

   dmac_burst_seq #(.LEN_W(LEN_W)) u_dst_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .kill  (flush),
      .start (dst_start),
      .len   (d_len),
      .ack   (dst_ack),
      .move  (dst_give)
   );

   dmac_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (src_take),
      .din   (src_data),
      .pop   (dst_give),
      .dout  (dst_data),
      .count (fifo_count)
   );

   assign chan_active = (fifo_count != '0);

   // register readback, unused bits zero
   always_comb begin
      reg_rdata = '0;
      if (!reg_sel) begin
         reg_rdata[SIZE_LSB +: SIZE_W] = rem_val;
         reg_rdata[SRC_LSB  +: CODE_W] = src_code;
         reg_rdata[DST_LSB  +: CODE_W] = dst_code;
      end else begin
         reg_rdata[EN_BIT]   = en_q;
         reg_rdata[FLOW_BIT] = flow_q;
         reg_rdata[ACT_BIT]  = chan_active;
         reg_rdata[HALT_BIT] = halt_q;
      end
   end
endmodule

// File: rtl/dmac_chk.sv
`timescale 1ns/1ps
module dmac_chk #(
   parameter int DEPTH  = 4,
   parameter int CW     = 3,
   parameter int SIZE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              flow,
   input logic              halt,
   input logic [CW-1:0]     count,
   input logic [SIZE_W-1:0] rem,
   input logic              src_ack,
   input logic              src_take,
   input logic              dst_ack,
   input logic              dst_give,
   input logic              tc,
   input logic              reg_wr,
   input logic              reg_sel
);
   logic ctl_wr;
   assign ctl_wr = reg_wr && !reg_sel;

   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count) <= DEPTH);

   a_r2_src_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
      src_ack |-> src_take);

   a_r3_dst_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
      dst_ack |-> dst_give);

   a_r7_halt_blocks_src: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> !src_ack);

   a_r9_tc_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> !en);

   a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en) |-> count == '0);

   a_r4_rem_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_give && flow && !ctl_wr && rem != '0) |=> rem == $past(rem) - SIZE_W'(1));

   a_r5_rem_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!flow && !ctl_wr) |=> $stable(rem));
endmodule

bind dmac_channel dmac_chk #(.DEPTH(DEPTH), .CW(CNT_W), .SIZE_W(dmac_pkg::SIZE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en_q),
   .flow     (flow_q),
   .halt     (halt_q),
   .count    (fifo_count),
   .rem      (rem_val),
   .src_ack  (src_ack),
   .src_take (src_take),
   .dst_ack  (dst_ack),
   .dst_give (dst_give),
   .tc       (tc),
   .reg_wr   (reg_wr),
   .reg_sel  (reg_sel)
);

// File: tb/dmac_channel_test.sv
`timescale 1ns/1ps
module dmac_channel_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        src_breq = 1'b0, src_ack, src_take;
   logic [31:0] src_data = '0;
   logic        dst_breq = 1'b0, dst_ack, dst_give;
   logic [31:0] dst_data;
   logic        chan_active, tc;

   dmac_channel #(.DATA_W(32), .DEPTH(4)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .src_breq(src_breq), .src_ack(src_ack), .src_take(src_take), .src_data(src_data),
      .dst_breq(dst_breq), .dst_ack(dst_ack), .dst_give(dst_give), .dst_data(dst_data),
      .chan_active(chan_active), .tc(tc)
   );

   always #10 clk = ~clk;

   int checks = 0, bad = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   function automatic int blen(input int code);
      return (code == 0) ? 1 : (1 << (code + 1));
   endfunction
   function automatic int imin(input int a, input int b);
      return (a < b) ? a : b;
   endfunction
   function automatic logic [31:0] ctl(input int dc, input int sc, input int size);
      return (32'(dc) << 15) | (32'(sc) << 12) | 32'(size & 12'hFFF);
   endfunction

   // monitor state
   bit          mon_flow = 1'b0;
   int          cur_size = 0, cur_sc = 0, cur_dc = 0;
   logic [31:0] s_seq = '0, d_seq = '0;
   int s_words = 0, d_words = 0, s_acks = 0, d_acks = 0;
   int s_cur = 0, d_cur = 0, s_exp = 0, d_exp = 0;
   bit s_prev = 1'b0, d_prev = 1'b0, tc_prev = 1'b0;
   int tc_cnt = 0, tc_wide = 0;
   int err_rem = 0, err_data = 0, err_sb = 0, err_db = 0;

   always @(negedge clk) begin
      if (mon_flow && !reg_sel && int'(reg_rdata[11:0]) != cur_size - d_words) err_rem++;
      if (src_ack) begin
         s_acks++;
         s_cur = 0;
         s_exp = imin(blen(cur_sc), cur_size - s_words);
      end
      src_data = s_seq;
      if (src_take) begin
         s_seq++;
         s_words++;
         s_cur++;
      end
      if (s_prev && !src_take && mon_flow && s_cur != s_exp) err_sb++;
      s_prev = src_take;
      if (dst_ack) begin
         d_acks++;
         d_cur = 0;
         d_exp = imin(blen(cur_dc), cur_size - d_words);
      end
      if (dst_give) begin
         if (mon_flow && dst_data != d_seq) err_data++;
         d_seq++;
         d_words++;
         d_cur++;
      end
      if (d_prev && !dst_give && mon_flow && d_cur != d_exp) err_db++;
      d_prev = dst_give;
      if (tc) begin
         tc_cnt++;
         if (tc_prev) tc_wide++;
      end
      tc_prev = tc;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #2;
   endtask

   task automatic wr(input bit sel, input logic [31:0] d);
      reg_sel = sel;
      reg_wdata = d;
      reg_wr = 1'b1;
      tick(1);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input bit sel, output logic [31:0] v);
      reg_sel = sel;
      #1;
      v = reg_rdata;
   endtask

   task automatic run_flow(input int size, input int sc, input int dc);
      logic [31:0] v;
      int n;
      mon_flow = 1'b0;
      src_breq = 1'b0;
      dst_breq = 1'b0;
      cur_size = size; cur_sc = sc; cur_dc = dc;
      wr(1'b0, ctl(dc, sc, size));
      wr(1'b1, 32'h3);
      s_words = 0; d_words = 0; d_seq = s_seq;
      tc_cnt = 0; tc_wide = 0;
      err_rem = 0; err_data = 0; err_sb = 0; err_db = 0;
      reg_sel = 1'b0;
      mon_flow = 1'b1;
      src_breq = 1'b1;
      dst_breq = 1'b1;
      n = 0;
      while (tc_cnt == 0 && n < 3000) begin
         tick(1);
         n++;
      end
      tick(3);
      mon_flow = 1'b0;
      src_breq = 1'b0;
      dst_breq = 1'b0;
      chk(tc_cnt == 1,     "R9 terminal-count pulses", tc_cnt, 1);
      chk(tc_wide == 0,    "R9 terminal-count width", tc_wide, 0);
      chk(d_words == size, "R4 words delivered", d_words, size);
      chk(s_words == size, "R12 words fetched", s_words, size);
      chk(err_data == 0,   "R3 data order mismatches", err_data, 0);
      chk(err_rem == 0,    "R4 remaining readback mismatches", err_rem, 0);
      chk(err_sb == 0,     "R2 R12 source burst length mismatches", err_sb, 0);
      chk(err_db == 0,     "R3 destination burst length mismatches", err_db, 0);
      rd(1'b1, v);
      chk(v[0] == 1'b0,    "R9 enable cleared", v[0], 0);
      chk(chan_active == 1'b0, "R8 idle after transfer", chan_active, 0);
   endtask

   initial begin
      logic [31:0] v;
      int a0, w0;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      rd(1'b0, v); chk(v == 32'h0, "R1 control reset", v, 0);
      rd(1'b1, v); chk(v == 32'h0, "R1 config reset", v, 0);
      chk({src_ack, src_take, dst_ack, dst_give, chan_active, tc} == 6'b0,
          "R1 outputs reset", {src_ack, src_take, dst_ack, dst_give, chan_active, tc}, 0);

      // R11 reserved bits
      wr(1'b1, 32'hFFF8_0000);
      rd(1'b1, v); chk(v == 32'h0, "R11 config reserved bits", v, 0);
      wr(1'b0, 32'hFFFC_0000);
      rd(1'b0, v); chk(v == 32'h0, "R11 control reserved bits", v, 0);

      // R2 field readback
      wr(1'b0, ctl(5, 6, 12'hABC));
      rd(1'b0, v); chk(v == ctl(5, 6, 12'hABC), "R2 control field readback", v, ctl(5, 6, 12'hABC));

      // R6 oversize burst never granted, 4-word burst fills FIFO once
      wr(1'b0, ctl(0, 2, 0));
      wr(1'b1, 32'h1);
      a0 = s_acks;
      src_breq = 1'b1;
      tick(20);
      chk(s_acks == a0, "R6 8-word source burst refused", s_acks - a0, 0);
      wr(1'b0, ctl(0, 1, 0));
      a0 = s_acks; w0 = s_words;
      tick(20);
      chk(s_acks - a0 == 1, "R6 single 4-word grant", s_acks - a0, 1);
      chk(s_words - w0 == 4, "R2 4-word burst length", s_words - w0, 4);
      chk(chan_active == 1'b1, "R8 active port with data", chan_active, 1);
      rd(1'b1, v); chk(v[17] == 1'b1, "R8 active bit with data", v[17], 1);

      // R7 halt drains with shortened destination burst
      wr(1'b0, ctl(3, 1, 0));
      wr(1'b1, 32'h0004_0001);
      a0 = s_acks; w0 = d_words;
      dst_breq = 1'b1;
      tick(20);
      chk(d_words - w0 == 4, "R7 drained words", d_words - w0, 4);
      chk(s_acks == a0, "R7 no source grant while halted", s_acks - a0, 0);
      chk(chan_active == 1'b0, "R8 inactive after drain", chan_active, 0);
      rd(1'b1, v); chk(v[18:17] == 2'b10, "R7 R8 halt set active clear", v[18:17], 2);

      // R10 disable while active loses data
      dst_breq = 1'b0;
      wr(1'b1, 32'h1);
      tick(12);
      chk(chan_active == 1'b1, "R10 refilled before disable", chan_active, 1);
      wr(1'b1, 32'h0);
      tick(1);
      chk(chan_active == 1'b0, "R10 flush on disable", chan_active, 0);
      src_breq = 1'b0;
      wr(1'b0, ctl(0, 1, 0));
      wr(1'b1, 32'h1);
      w0 = d_words;
      dst_breq = 1'b1;
      tick(10);
      chk(d_words == w0, "R10 flushed words never delivered", d_words - w0, 0);
      wr(1'b1, 32'h0);
      dst_breq = 1'b0;

      // R5 size ignored without flow control
      wr(1'b0, ctl(0, 0, 5));
      wr(1'b1, 32'h1);
      tc_cnt = 0;
      w0 = d_words;
      src_breq = 1'b1;
      dst_breq = 1'b1;
      tick(30);
      chk(d_words - w0 >= 8, "R5 transfer continues past size", d_words - w0, 8);
      rd(1'b0, v); chk(v[11:0] == 12'd5, "R5 size readback unchanged", v[11:0], 5);
      chk(tc_cnt == 0, "R5 no terminal count", tc_cnt, 0);
      src_breq = 1'b0;
      dst_breq = 1'b0;
      wr(1'b1, 32'h0);
      tick(2);

      // flow-mode sweep over sizes and burst codes
      for (int size = 1; size <= 9; size++)
         for (int sc = 0; sc < 8; sc++)
            for (int dc = 0; dc < 8; dc++)
               if ((blen(sc) <= 4 || size <= 4) && (blen(dc) <= 4 || size <= 4))
                  run_flow(size, sc, dc);
      run_flow(12, 1, 0);
      run_flow(13, 0, 1);
      run_flow(300, 1, 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule